// File: doc/BRIEF.md
# Pipelined SPI ADC Channel Sequencer

This block drives a multi-channel successive-approximation ADC over a four-wire serial link. The converter accepts a 14-bit configuration word in every frame. The sample it shifts back during that frame was set up two frames earlier. The block keeps a shadow copy of the configuration and takes channel-read requests on a valid/ready handshake. For each request it emits the frames needed so that the returned sample really belongs to the requested channel. It then presents the right-aligned sample with its channel number.

After reset the block programs the converter with a complete configuration word and runs two discarded channel-0 reads before it accepts any request. The serial clock is a divided system clock. Frames are either one 16-bit word or two 8-bit bytes under a single chip-select window. Converter resolution (14 or 16 bits), frame style, clock divide, inter-frame idle time and the reference selection are parameters.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The configuration word is laid out from bit 13 down as: update flag, 3-bit input mode, 3-bit channel, full-bandwidth bit, 3-bit reference code, 2-bit sequencer mode, readback-disable bit. Every frame carries it left-aligned in 16 bits, with the two low bits zero.
- R2: After reset the first frame writes update=1, input mode 7, channel 0, full bandwidth=1, reference code=REF_SEL, sequencer 0, readback-disable=1. Two channel-0 reads follow, each a configuration frame and then a data frame. Their samples are never presented.
- R3: A request for the channel used last sends one configuration frame, in which only the channel field differs from the shadow. It then sends one data frame whose MOSI bits are all zero.
- R4: A request for a different channel sends the configuration frame twice before the data frame. The presented sample is the one converted with the requested channel.
- R5: The last-used channel is 0 after reset. It changes only when the data frame of a read completes.
- R6: req_ready is low during power-up and while a read is in progress, and a request is taken only when valid and ready are both high. While chip select is low, ready is low.
- R7: A result appears as a one-cycle rsp_valid pulse with rsp_chan. rsp_data is the received 16-bit frame shifted right by 16−RES_BITS and zero-extended.
- R8: The link uses SPI mode 0 with the MSB first. SCLK is low whenever chip select is high, and MOSI is stable at every rising SCLK edge.
- R9: With BYTE_MODE=1 a frame is two bytes, high byte first, sent in one chip-select window of 16 SCLK pulses. SCLK stays low for an extra 2·SCLK_DIV cycles between the bytes.
- R10: Chip select stays high for at least GAP_CYCLES system clocks between two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Channel-read request valid |
| req_ready | output | 1 | Block can accept a request |
| req_chan | input | 3 | Requested channel |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_chan | output | 3 | Channel of the result |
| rsp_data | output | 16 | Right-aligned sample |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |

## Verification
The bench builds the block with RES_BITS=14, BYTE_MODE=1, SCLK_DIV=2, GAP_CYCLES=20 and REF_SEL=1. The 14-bit setting exercises the padding drop, because the bench's converter model fills the two low bits with ones. Byte mode brings the mid-frame SCLK pause and the single chip-select window within reach. The small divide and gap keep each frame short enough for a long channel sequence, with repeats and changes, to fit the run. The 16-bit resolution and single-word frame variants are not built by this bench.

// File: rtl/adc_seq_pkg.sv
// Shared configuration-word type and helpers for the ADC sequencer.
// Assumes a 14-bit configuration word carried MSB-aligned in 16 bits.
package adc_seq_pkg;
    localparam int CFG_W   = 14;
    localparam int FRAME_W = 16;
    localparam int CH_W    = 3;
    localparam logic [2:0] MODE_UNI_GND = 3'd7;

    typedef struct packed {
        logic       upd;
        logic [2:0] in_mode;
        logic [2:0] chan;
        logic       full_bw;
        logic [2:0] ref_code;
        logic [1:0] seq;
        logic       rb_off;
    } cfg_t;

    // Build the power-up configuration for a given reference code
    function automatic cfg_t boot_cfg(input logic [2:0] ref_code);
        cfg_t c;
        c.upd      = 1'b1;
        c.in_mode  = MODE_UNI_GND;
        c.chan     = '0;
        c.full_bw  = 1'b1;
        c.ref_code = ref_code;
        c.seq      = 2'b00;
        c.rb_off   = 1'b1;
        return c;
    endfunction

    // Place the configuration word MSB-aligned in a frame
    function automatic logic [FRAME_W-1:0] cfg_frame(input cfg_t c);
        return {c, 2'b00};
    endfunction
endpackage

// File: rtl/adc_spi_shifter.sv
// Frame engine: shifts one 16-bit word out on MOSI and in from MISO in
// SPI mode 0, MSB first, then holds chip select high for GAP_CYCLES.
// Assumes SCLK_DIV >= 2 and GAP_CYCLES >= 1. In byte mode SCLK pauses
// between the two bytes while chip select stays low.
module adc_spi_shifter #(
    parameter int BYTE_MODE  = 0,
    parameter int SCLK_DIV   = 4,
    parameter int GAP_CYCLES = 250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] tx_word,
    output logic        idle,
    output logic        done,
    output logic [15:0] rx_word,
    output logic        sclk,
    output logic        cs_n,
    output logic        mosi,
    input  logic        miso
);
    localparam int DIV_W   = $clog2(SCLK_DIV + 1);
    localparam int PAUSE_N = 2 * SCLK_DIV;
    localparam int PAU_W   = $clog2(PAUSE_N + 1);
    localparam int GAP_W   = $clog2(GAP_CYCLES + 1);

    typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_PAUSE, SH_GAP} sh_state_t;

    sh_state_t        st;
    logic [DIV_W-1:0] div_cnt;
    logic [PAU_W-1:0] pau_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic [4:0]       bit_cnt;
    logic             rise_next;
    logic [15:0]      tx_sh;
    logic             tick;
    logic             byte_edge;

    assign tick = (div_cnt == DIV_W'(SCLK_DIV - 1));
    assign idle = (st == SH_IDLE);
    assign mosi = tx_sh[15];

    // Select whether a byte boundary pause exists
    generate
        if (BYTE_MODE != 0) begin : g_byte
            assign byte_edge = (bit_cnt == 5'd7);
        end else begin : g_word
            assign byte_edge = 1'b0;
        end
    endgenerate

    // Frame sequencing, clock generation and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SH_IDLE;
            div_cnt   <= '0;
            pau_cnt   <= '0;
            gap_cnt   <= '0;
            bit_cnt   <= '0;
            rise_next <= 1'b1;
            tx_sh     <= '0;
            rx_word   <= '0;
            sclk      <= 1'b0;
            cs_n      <= 1'b1;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SH_IDLE: begin
                    if (start) begin
                        cs_n      <= 1'b0;
                        tx_sh     <= tx_word;
                        div_cnt   <= '0;
                        bit_cnt   <= '0;
                        rise_next <= 1'b1;
                        st        <= SH_RUN;
                    end
                end
                SH_RUN: begin
                    div_cnt <= tick ? '0 : div_cnt + 1'b1;
                    if (tick) begin
                        if (rise_next) begin
                            sclk      <= 1'b1;
                            rx_word   <= {rx_word[14:0], miso};
                            rise_next <= 1'b0;
                        end else begin
                            sclk      <= 1'b0;
                            rise_next <= 1'b1;
                            tx_sh     <= {tx_sh[14:0], 1'b0};
                            bit_cnt   <= bit_cnt + 1'b1;
                            if (bit_cnt == 5'd15) begin
                                cs_n    <= 1'b1;
                                done    <= 1'b1;
                                gap_cnt <= '0;
                                st      <= SH_GAP;
                            end else if (byte_edge) begin
                                pau_cnt <= '0;
                                st      <= SH_PAUSE;
                            end
                        end
                    end
                end
                SH_PAUSE: begin
                    pau_cnt <= pau_cnt + 1'b1;
                    if (pau_cnt == PAU_W'(PAUSE_N - 1)) begin
                        div_cnt <= '0;
                        st      <= SH_RUN;
                    end
                end
                default: begin
                    gap_cnt <= gap_cnt + 1'b1;
                    if (gap_cnt == GAP_W'(GAP_CYCLES - 1)) st <= SH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
// Read sequencer: keeps the configuration shadow and the last-used
// channel, orders configuration and data frames around the converter's
// two-frame latency, and runs the power-up sequence.
// Assumes the frame engine pulses done once per started frame.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS = 16,
    parameter int REF_SEL  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [CH_W-1:0] req_chan,
    output logic            rsp_valid,
    output logic [CH_W-1:0] rsp_chan,
    output logic [15:0]     rsp_data,
    output logic            frm_start,
    output logic [15:0]     frm_word,
    input  logic            frm_idle,
    input  logic            frm_done,
    input  logic [15:0]     frm_rx
);
    localparam int PAD = FRAME_W - RES_BITS;

    typedef enum logic [2:0] {S_BOOT, S_CFG, S_CFG2, S_DATA, S_IDLE} seq_state_t;

    seq_state_t      st;
    cfg_t            shadow;
    logic [CH_W-1:0] last_ch;
    logic [CH_W-1:0] cur_ch;
    logic [1:0]      dummy_left;
    logic            launched;

    assign req_ready = (st == S_IDLE);
    assign frm_start = (st != S_IDLE) && !launched && frm_idle;
    assign frm_word  = (st == S_DATA) ? '0 : cfg_frame(shadow);

    // Step through the frame sequence for power-up and each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= S_BOOT;
            shadow     <= boot_cfg(3'(REF_SEL));
            last_ch    <= '0;
            cur_ch     <= '0;
            dummy_left <= 2'd2;
            launched   <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_chan   <= '0;
            rsp_data   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (frm_start) launched <= 1'b1;
            if (st == S_IDLE) begin
                if (req_valid) begin
                    cur_ch      <= req_chan;
                    shadow.chan <= req_chan;
                    st          <= S_CFG;
                end
            end else if (frm_done) begin
                launched <= 1'b0;
                case (st)
                    S_BOOT: st <= S_CFG;
                    S_CFG:  st <= (cur_ch != last_ch) ? S_CFG2 : S_DATA;
                    S_CFG2: st <= S_DATA;
                    default: begin
                        last_ch <= cur_ch;
                        st      <= S_IDLE;
                        if (dummy_left != 2'd0) begin
                            dummy_left <= dummy_left - 1'b1;
                            if (dummy_left != 2'd1) st <= S_CFG;
                        end else begin
                            rsp_valid <= 1'b1;
                            rsp_chan  <= cur_ch;
                            rsp_data  <= frm_rx >> PAD;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Top of the ADC channel sequencer: joins the read sequencer to the
// serial frame engine. Assumes RES_BITS is 14 or 16 and SCLK_DIV >= 2.
module adc_seq_ctrl #(
    parameter int RES_BITS   = 16,
    parameter int BYTE_MODE  = 0,
    parameter int SCLK_DIV   = 4,
    parameter int GAP_CYCLES = 250,
    parameter int REF_SEL    = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_chan,
    output logic        rsp_valid,
    output logic [2:0]  rsp_chan,
    output logic [15:0] rsp_data,
    output logic        spi_sclk,
    output logic        spi_cs_n,
    output logic        spi_mosi,
    input  logic        spi_miso
);
    logic        frm_start;
    logic [15:0] frm_word;
    logic        frm_idle;
    logic        frm_done;
    logic [15:0] frm_rx;

    adc_seq_fsm #(
        .RES_BITS (RES_BITS),
        .REF_SEL  (REF_SEL)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_chan  (req_chan),
        .rsp_valid (rsp_valid),
        .rsp_chan  (rsp_chan),
        .rsp_data  (rsp_data),
        .frm_start (frm_start),
        .frm_word  (frm_word),
        .frm_idle  (frm_idle),
        .frm_done  (frm_done),
        .frm_rx    (frm_rx)
    );

    adc_spi_shifter #(
        .BYTE_MODE  (BYTE_MODE),
        .SCLK_DIV   (SCLK_DIV),
        .GAP_CYCLES (GAP_CYCLES)
    ) shf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (frm_start),
        .tx_word (frm_word),
        .idle    (frm_idle),
        .done    (frm_done),
        .rx_word (frm_rx),
        .sclk    (spi_sclk),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .miso    (spi_miso)
    );
endmodule

// File: rtl/adc_seq_checker.sv
// Protocol checker for the ADC sequencer ports, bound to the top.
// Assumes synchronous active-low reset on the same clock.
module adc_seq_checker #(
    parameter int GAP_CYCLES = 250
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rsp_valid,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_mosi
);
    localparam int GW = $clog2(GAP_CYCLES + 1) + 1;
    logic [GW-1:0] high_cnt;

    // Count cycles chip select has been high, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) high_cnt <= GW'(GAP_CYCLES);
        else if (!spi_cs_n) high_cnt <= '0;
        else if (high_cnt < GW'(GAP_CYCLES)) high_cnt <= high_cnt + 1'b1;
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !req_ready); // R6
    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk); // R8
    AST_MOSI_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $rose(spi_sclk)) |-> $stable(spi_mosi)); // R8
    AST_FRAME_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (high_cnt >= GW'(GAP_CYCLES))); // R10
endmodule

bind adc_seq_ctrl adc_seq_checker #(.GAP_CYCLES(GAP_CYCLES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_mosi  (spi_mosi)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Bench: behavioural converter model with two-frame latency, expected
// frame list built from the requests, and per-clock port checks.
module adc_seq_ctrl_tb_top;
    localparam int RES  = 14;
    localparam int DIV  = 2;
    localparam int GAP  = 20;
    localparam int REFC = 1;
    localparam int NREQ = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [2:0]  req_chan;
    logic        rsp_valid;
    logic [2:0]  rsp_chan;
    logic [15:0] rsp_data;
    logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    always #4 clk = ~clk;

    adc_seq_ctrl #(.RES_BITS(RES), .BYTE_MODE(1), .SCLK_DIV(DIV),
                   .GAP_CYCLES(GAP), .REF_SEL(REFC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .rsp_valid(rsp_valid), .rsp_chan(rsp_chan),
        .rsp_data(rsp_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    int n_chk = 0;
    int n_fail = 0;
    int n_rsp = 0;
    int exp_frames[$];
    int exp_ch[$];
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int cfg_of(input int ch);
        logic [13:0] c;
        c = {1'b1, 3'd7, 3'(ch), 1'b1, 3'(REFC), 2'b00, 1'b1};
        return int'({c, 2'b00});
    endfunction

    // Converter model and per-clock port checks, sampled on falling edges
    initial begin
        bit prev_cs = 1'b1, prev_sclk = 1'b0, prev_rv = 1'b0, seen_frame = 1'b0;
        int bitidx = 0, hi_cnt = 0, pause_cnt = 0, nconv = 0, nfrm = 0;
        logic [15:0] rxw = '0, outw = '0;
        logic [13:0] eff1 = '0, eff2 = '0;
        int out_ch = -1, last_ch = -1, last_val = 0;
        spi_miso = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_cs && !spi_cs_n) begin
                    if (seen_frame) chk(hi_cnt >= GAP, "R10 idle gap", hi_cnt, GAP);
                    chk(!prev_sclk, "R8 sclk low at select", prev_sclk, 0);
                    seen_frame = 1'b1;
                    bitidx = 0; pause_cnt = 0; rxw = '0;
                    if (nfrm >= 2) begin
                        out_ch = int'(eff2[9:7]);
                        outw = {3'(out_ch), 11'(nconv), 2'b11};
                        nconv++;
                    end else begin
                        out_ch = -1; outw = '0;
                    end
                    spi_miso = outw[15];
                end
                if (!spi_cs_n && spi_sclk && !prev_sclk) begin
                    rxw = {rxw[14:0], spi_mosi};
                    bitidx++;
                end
                if (!spi_cs_n && !spi_sclk && prev_sclk && bitidx < 16)
                    spi_miso = outw[15 - bitidx];
                if (!spi_cs_n && !spi_sclk && bitidx == 8) pause_cnt++;
                if (!prev_cs && spi_cs_n) begin
                    chk(bitidx == 16, "R9 bits in one select window", bitidx, 16);
                    chk(pause_cnt >= 3 * DIV, "R9 byte pause", pause_cnt, 3 * DIV);
                    if (exp_frames.size() == 0)
                        chk(0, "R3 unexpected frame", int'(rxw), -1);
                    else begin
                        int e;
                        e = exp_frames.pop_front();
                        chk(int'(rxw) == e, "R1 R2 R3 R4 frame word", int'(rxw), e);
                    end
                    eff2 = eff1;
                    if (rxw[15]) eff1 = rxw[15:2];
                    nfrm++;
                    last_ch = out_ch;
                    last_val = int'(outw[15:2]);
                end
                if (spi_cs_n) hi_cnt++; else hi_cnt = 0;
                if (!spi_cs_n && req_ready) chk(0, "R6 ready while busy", 1, 0);
                if (rsp_valid) begin
                    int ec;
                    chk(!prev_rv, "R7 single-cycle strobe", 1, 0);
                    ec = (exp_ch.size() > 0) ? exp_ch.pop_front() : -1;
                    chk(int'(rsp_chan) == ec, "R7 rsp_chan", int'(rsp_chan), ec);
                    chk(last_ch == ec, "R4 sample channel", last_ch, ec);
                    chk(int'(rsp_data) == last_val, "R7 right-aligned data", int'(rsp_data), last_val);
                    n_rsp++;
                end
                prev_rv = rsp_valid;
            end
            prev_cs = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    task automatic send(input int ch, inout int last);
        req_valid = 1'b1;
        req_chan = 3'(ch);
        while (!req_ready) @(negedge clk);
        exp_frames.push_back(cfg_of(ch));
        if (ch != last) exp_frames.push_back(cfg_of(ch));
        exp_frames.push_back(0);
        exp_ch.push_back(ch);
        last = ch;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Stimulus: reset, power-up expectations, request sequence
    initial begin
        int seq[NREQ] = '{0, 0, 3, 3, 5, 2, 2, 7, 0, 0};
        int last = 0;
        rst_n = 1'b0; req_valid = 1'b0; req_chan = '0;
        repeat (5) @(negedge clk);
        chk(spi_cs_n && !spi_sclk, "R8 reset idle lines", {spi_cs_n, spi_sclk}, 2);
        chk(!rsp_valid, "R7 reset strobe", rsp_valid, 0);
        chk(!req_ready, "R6 not ready in reset", req_ready, 0);
        rst_n = 1'b1;
        // R2: full word, then two channel-0 reads (R5: last channel starts at 0)
        exp_frames.push_back(cfg_of(0));
        exp_frames.push_back(cfg_of(0));
        exp_frames.push_back(0);
        exp_frames.push_back(cfg_of(0));
        exp_frames.push_back(0);
        @(negedge clk);
        chk(!req_ready, "R6 not ready during power-up", req_ready, 0);
        for (int i = 0; i < NREQ; i++) send(seq[i], last);
        while (n_rsp < NREQ) @(negedge clk);
        repeat (100) @(negedge clk);
        chk(exp_frames.size() == 0, "R5 all frames seen", exp_frames.size(), 0);
        chk(n_rsp == NREQ, "R2 no dummy results", n_rsp, NREQ);
        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(negedge clk);
        if (!done_flag) begin
            chk(0, "watchdog", n_rsp, NREQ);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule